// File: doc/BRIEF.md
# Prioritized Peripheral Pin Multiplexer Port

This block is an eight-bit general-purpose I/O port. Software sets its pins through a data register and a direction register on a simple register bus. The upper pin pair can also be taken over by on-chip peripherals. Each of these peripherals gets the pins only while its enable input is high. When more than one is enabled, a fixed priority decides which one owns the pins. The block drives the pad-control signals for each pin: output data, output enable and open-drain select. It also sends synchronized pin levels back to the peripheral that owns the pins.

Bit 7 carries a transmit line, an I2C clock or a general-purpose bit. Bit 6 carries a receive line, an I2C data line or a general-purpose bit. Bits 1 and 0 are plain general-purpose I/O. Bits 5 to 2 are not implemented. Every pin input passes through a two-flop synchronizer before the block uses it.

Top module: `pinmux_port`

## Requirements
- R1: On bits 7 and 6, the enabled source with the highest rank owns the pins. The ranks, from highest to lowest, are: CAN controller B, then I2C, then CAN controller A, then the general-purpose registers. When a CAN controller owns the pair, bit 7 drives that controller's transmit value with output enable 1 and open-drain 0. Bit 6 is then an input, with output enable 0, output value 0 and open-drain 0.
- R2: A peripheral whose enable input is low never owns the pins. Ownership goes to the next enabled source down the ranking. When no peripheral is enabled, the general-purpose registers own the pins.
- R3: While I2C owns the pair, both pins have open-drain set to 1 and output value 0. Bit 7 has output enable equal to the inverse of the I2C clock output, and bit 6 has output enable equal to the inverse of the I2C data output.
- R4: A read at the data offset returns, for each implemented bit, the data-register bit if that bit's direction is 1 (output). If the direction is 0 (input), it returns the synchronized pin level. A pin change first appears in the read two clock edges later.
- R5: The data register can be written at any time, including while a peripheral owns the pin. The stored value takes effect once the general-purpose registers own the pin again.
- R6: Bits 5 to 2 of both registers read as 0 and ignore writes. Their pads always have output value, output enable and open-drain all at 0.
- R7: The implemented direction bits reset to 0, so every pad output enable is 0 after reset while no peripheral is enabled. The data register has no reset value.
- R8: The data register is at offset 0x28 and the direction register is at offset 0x2A. A read at any other offset returns 0, and a write there changes nothing.
- R9: Bits 1 and 0 always follow the general-purpose registers: output value from the data bit, output enable from the direction bit, and open-drain 0.
- R10: Each peripheral receive input carries the synchronized pin level only while that peripheral owns the pin. Otherwise it holds 1 (idle). CAN receive and I2C data use bit 6, and I2C clock uses bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pin_in | input | 8 | Raw pin levels from pads |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_od | output | 8 | Pad open-drain select |
| canb_en | input | 1 | CAN controller B enable (highest rank) |
| canb_tx | input | 1 | CAN controller B transmit |
| canb_rx | output | 1 | CAN controller B receive |
| i2c_en | input | 1 | I2C enable |
| i2c_scl_o | input | 1 | I2C clock out, 0 pulls low |
| i2c_sda_o | input | 1 | I2C data out, 0 pulls low |
| i2c_scl_i | output | 1 | I2C clock in |
| i2c_sda_i | output | 1 | I2C data in |
| cana_en | input | 1 | CAN controller A enable |
| cana_tx | input | 1 | CAN controller A transmit |
| cana_rx | output | 1 | CAN controller A receive |

## Verification
Pad outputs react to the enables and to the peripheral transmit values in the same cycle. Register writes reach the pads and the read data one edge later. Pin levels reach the read data and the receive inputs two edges later. The bench drives its inputs 5 ns after a rising edge and updates its behavioural model on each rising edge. The model keeps a two-stage history of the pins and compares every output at the falling edge, so each result is checked in the first cycle it is due. Data-register bits that have not been written since power-up are left out of the comparison.

// File: rtl/pinmux_port.sv
module pinmux_port #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h28,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe,
  output logic [7:0]        pad_od,
  input  logic              canb_en,
  input  logic              canb_tx,
  output logic              canb_rx,
  input  logic              i2c_en,
  input  logic              i2c_scl_o,
  input  logic              i2c_sda_o,
  output logic              i2c_scl_i,
  output logic              i2c_sda_i,
  input  logic              cana_en,
  input  logic              cana_tx,
  output logic              cana_rx
);
  localparam logic [7:0] IMPL = 8'hC3;

  logic [7:0] port_q, dir_q, meta_q, sync_q;
  logic       own_b, own_i, own_a;

  assign own_b = canb_en;
  assign own_i = i2c_en & ~canb_en;
  assign own_a = cana_en & ~canb_en & ~i2c_en;

  always_ff @(posedge clk)
    if (wr_en && addr == DATA_OFS) port_q <= wdata & IMPL;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q  <= '0;
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      if (wr_en && addr == DIR_OFS) dir_q <= wdata & IMPL;
      meta_q <= pin_in & IMPL;
      sync_q <= meta_q;
    end

  always_comb begin
    pad_out = port_q & IMPL;
    pad_oe  = dir_q & IMPL;
    pad_od  = '0;
    if (own_b || own_a) begin
      pad_out[7] = own_b ? canb_tx : cana_tx;
      pad_oe[7]  = 1'b1;
      pad_out[6] = 1'b0;
      pad_oe[6]  = 1'b0;
    end else if (own_i) begin
      pad_out[7:6] = 2'b00;
      pad_oe[7:6]  = {~i2c_scl_o, ~i2c_sda_o};
      pad_od[7:6]  = 2'b11;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == DATA_OFS)     rdata = ((port_q & dir_q) | (sync_q & ~dir_q)) & IMPL;
    else if (addr == DIR_OFS) rdata = dir_q;
  end

  assign canb_rx   = own_b ? sync_q[6] : 1'b1;
  assign cana_rx   = own_a ? sync_q[6] : 1'b1;
  assign i2c_sda_i = own_i ? sync_q[6] : 1'b1;
  assign i2c_scl_i = own_i ? sync_q[7] : 1'b1;
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rdata,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_od,
  input logic       canb_en,
  input logic       canb_tx,
  input logic       i2c_en,
  input logic       i2c_scl_o,
  input logic       cana_en,
  input logic       cana_tx,
  input logic       cana_rx
);
  AST_CANB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    canb_en |-> (pad_out[7] == canb_tx && pad_oe[7] && !pad_oe[6] && pad_od[7:6] == 2'b00)); // R1
  AST_CANA_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cana_en && !canb_en && !i2c_en) |-> (pad_out[7] == cana_tx && pad_od[7:6] == 2'b00)); // R2
  AST_I2C_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_en && !canb_en) |-> (pad_od[7:6] == 2'b11 && pad_out[7:6] == 2'b00 && pad_oe[7] == !i2c_scl_o)); // R3
  AST_UNIMPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out[5:2] == 4'b0 && pad_oe[5:2] == 4'b0 && pad_od[5:2] == 4'b0 && rdata[5:2] == 4'b0)); // R6
  AST_LOW_PAIR_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    pad_od[1:0] == 2'b00); // R9
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cana_en && !canb_en && !i2c_en) |-> cana_rx); // R10
endmodule

bind pinmux_port pinmux_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_od(pad_od), .canb_en(canb_en), .canb_tx(canb_tx), .i2c_en(i2c_en),
  .i2c_scl_o(i2c_scl_o), .cana_en(cana_en), .cana_tx(cana_tx), .cana_rx(cana_rx)
);

// File: tb/pinmux_port_tb_top.sv
module pinmux_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, pin_in = '0;
  logic wr_en = 1'b0;
  logic canb_en = 0, canb_tx = 1, i2c_en = 0, i2c_scl_o = 1, i2c_sda_o = 1, cana_en = 0, cana_tx = 1;
  logic [7:0] rdata, pad_out, pad_oe, pad_od;
  logic canb_rx, i2c_scl_i, i2c_sda_i, cana_rx;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pinmux_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .canb_en(canb_en), .canb_tx(canb_tx), .canb_rx(canb_rx),
    .i2c_en(i2c_en), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .i2c_scl_i(i2c_scl_i), .i2c_sda_i(i2c_sda_i),
    .cana_en(cana_en), .cana_tx(cana_tx), .cana_rx(cana_rx));

  // behavioural model state
  logic [7:0] m_port = '0, m_known = '0, m_dir = '0;
  logic [7:0] hist[2] = '{8'h00, 8'h00};

  always @(posedge clk) begin
    if (wr_en && addr == 8'h28) begin m_port = wdata & 8'hC3; m_known = 8'hFF; end
    if (!rst_n) begin
      m_dir = '0; hist[0] = '0; hist[1] = '0;
    end else begin
      if (wr_en && addr == 8'h2A) m_dir = wdata & 8'hC3;
      hist[1] = hist[0];
      hist[0] = pin_in & 8'hC3;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp, logic [7:0] msk);
    tests++;
    if ((act & msk) !== (exp & msk)) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h (mask %h)", req, $time, act, exp, msk);
    end
  endtask

  always @(negedge clk) begin
    int own;
    logic [7:0] e_out, e_oe, e_od, e_rd, rmask, omask;
    own = canb_en ? 3 : i2c_en ? 2 : cana_en ? 1 : 0;
    e_out = m_port; e_oe = m_dir; e_od = '0; omask = 8'hFF;
    omask[7] = m_known[7]; omask[6] = m_known[6]; omask[1] = m_known[1]; omask[0] = m_known[0];
    if (own == 3 || own == 1) begin
      e_out[7] = (own == 3) ? canb_tx : cana_tx; e_oe[7] = 1; e_out[6] = 0; e_oe[6] = 0;
      omask[7] = 1; omask[6] = 1;
    end else if (own == 2) begin
      e_out[7:6] = 2'b00; e_oe[7] = ~i2c_scl_o; e_oe[6] = ~i2c_sda_o; e_od[7:6] = 2'b11;
      omask[7] = 1; omask[6] = 1;
    end
    chk("R1/R2 pad_out[7:6]", {6'b0, pad_out[7:6]}, {6'b0, e_out[7:6]}, {6'b0, omask[7:6]});
    chk("R1/R2 pad_oe[7:6]", {6'b0, pad_oe[7:6]}, {6'b0, e_oe[7:6]}, 8'hFF);
    chk("R3 pad_od[7:6]", {6'b0, pad_od[7:6]}, {6'b0, e_od[7:6]}, 8'hFF);
    chk("R6 unimplemented pads", {pad_out[5:2], pad_oe[5:2]}, 8'h00, 8'hFF);
    chk("R9 low pair", {pad_out[1:0], pad_oe[1:0], pad_od[1:0], 2'b0},
        {e_out[1:0], e_oe[1:0], 2'b00, 2'b0}, {omask[1:0], 6'b111100});
    rmask = 8'hFF;
    if (addr == 8'h28) begin
      e_rd = ((m_port & m_dir) | (hist[1] & ~m_dir)) & 8'hC3;
      rmask = ~(m_dir & ~m_known);
      chk("R4 data read", rdata, e_rd, rmask);
    end else if (addr == 8'h2A) chk("R8 direction read", rdata, m_dir, 8'hFF);
    else chk("R8 unmapped read", rdata, 8'h00, 8'hFF);
    chk("R10 rx returns", {4'b0, canb_rx, i2c_scl_i, i2c_sda_i, cana_rx},
        {4'b0, own == 3 ? hist[1][6] : 1'b1, own == 2 ? hist[1][7] : 1'b1,
         own == 2 ? hist[1][6] : 1'b1, own == 1 ? hist[1][6] : 1'b1}, 8'hFF);
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0; addr = 8'h28;
  endtask

  task automatic show_summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(20 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    show_summary();
    $finish;
  end

  initial begin
    step(3);
    chk("R7 reset oe", pad_oe, 8'h00, 8'hFF);
    rst_n = 1; step();
    addr = 8'h2A; #1 chk("R7 reset direction", rdata, 8'h00, 8'hFF);
    pin_in = 8'hFF; addr = 8'h28; step(2);
    wr(8'h28, 8'hA5);
    wr(8'h2A, 8'hFF);
    addr = 8'h2A; #1 chk("R6 direction reads masked", rdata, 8'hC3, 8'hFF);
    addr = 8'h28; #1 chk("R6 data reads masked", rdata, 8'h81, 8'hFF);
    wr(8'h33, 8'h00);
    addr = 8'h2A; #1 chk("R8 stray write ignored", rdata, 8'hC3, 8'hFF);
    for (int c = 0; c < 8; c++) begin
      {canb_en, i2c_en, cana_en} = c[2:0];
      canb_tx = c[0]; cana_tx = ~c[0]; i2c_scl_o = c[1]; i2c_sda_o = ~c[1];
      wr(8'h28, {c[0], c[1], 6'h00});
      pin_in = {c[1], c[0], 6'h15}; step(3);
    end
    {canb_en, i2c_en, cana_en} = 3'b010; wr(8'h28, 8'h40); step();
    {canb_en, i2c_en, cana_en} = 3'b000; step();
    chk("R5 write during ownership", {6'b0, pad_out[7:6]}, 8'h01, 8'hFF);
    wr(8'h2A, 8'h00);
    for (int i = 0; i < 600; i++) begin
      {canb_en, i2c_en, cana_en, canb_tx, cana_tx, i2c_scl_o, i2c_sda_o} = 7'($urandom);
      pin_in = 8'($urandom);
      if ($urandom % 4 == 0) wr(($urandom % 2) ? 8'h28 : 8'h2A, 8'($urandom));
      else begin addr = ($urandom % 8 == 0) ? 8'h11 : (($urandom % 3 == 0) ? 8'h2A : 8'h28); step(); end
    end
    show_summary();
    $finish;
  end
endmodule